// File: doc/BRIEF.md
# Per-Channel Trigger-Mode Interrupt Detector

This block watches fifteen interrupt request lines, numbered 1 to 15. Each line has its own 2-bit sensing mode:

- active-high level
- active-low level
- rising edge
- falling edge

Every line is brought into the clock domain through a two-stage synchronizer. It is then tested against its mode, and the result lands in a pending vector. Edge-sensed events are held in the vector until software writes a one to clear them. Level-sensed bits follow the line.

A fixed-priority encoder reports the highest-numbered pending channel, so a consumer can service requests in order. The modes are loaded through two 16-bit configuration words. One word covers the upper channels and the other covers the lower ones.

Top module: `irq_trigger_detect`

## Requirements
- R1: After reset, `pend_o` and `top_ch_o` are 0, and every channel senses an active-high level (mode 00).
- R2: Mode 00 (high level): the pending bit of a channel equals its synchronized input. A change on `irq_i` shows on `pend_o` at the third rising clock edge, and not at the second.
- R3: Mode 01 (low level): the pending bit is set while the synchronized input is 0. A channel whose input is held at 0 stays pending without interruption.
- R4: Mode 10 (rising edge): a 0-to-1 transition of the synchronized input sets the pending bit. The bit stays set after the input returns to 0.
- R5: Mode 11 (falling edge): a 1-to-0 transition of the synchronized input sets the pending bit, and the bit stays set afterwards.
- R6: A clock edge with bit n-1 of `clr_i` at 1 clears the pending bit of edge-mode channel n. Zero bits of `clr_i` leave their channels unchanged. `clr_i` has no effect on level-mode channels.
- R7: A write with `cfg_sel_i`=0 loads channels 8 to 15, channel n from `cfg_wdata_i[2(n-8)+1:2(n-8)]`. A write with `cfg_sel_i`=1 loads channels 1 to 7, channel n from `cfg_wdata_i[2(n-1)+1:2(n-1)]`. Each channel's mode is independent. Bit n-1 of `irq_i`, `clr_i` and `pend_o` belongs to channel n.
- R8: `top_ch_o` is the number of the highest pending channel (15 has top priority), or 0 when none is pending.
- R9: If an edge event and a clear fall on the same clock edge for one channel, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 15 | Raw request lines; bit n-1 is channel n |
| cfg_we_i | input | 1 | Mode word write strobe |
| cfg_sel_i | input | 1 | 0: channels 8-15, 1: channels 1-7 |
| cfg_wdata_i | input | 16 | Mode word, two bits per channel |
| clr_i | input | 15 | Write-one-to-clear mask for pending bits |
| pend_o | output | 15 | Pending vector |
| top_ch_o | output | 4 | Highest pending channel, 0 if none |

## Verification
On every cycle, the assertions check the following:

- level-mode bits track the synchronized line in the right polarity;
- edge-mode bits stay set unless cleared;
- a detected rising edge always sets its bit, even against a clear;
- each mode word write lands in the right channels;
- the encoder output always points at a set bit and reads 0 only for an empty vector.

Some behaviour only the bench scenarios can show: the exact three-edge latency from the pins, falling-edge capture, and a clear leaving level-mode bits alone. The same goes for the priority order among several pending channels and the continuous request from a tied-low line in low-level mode.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_chan_det.sv
module irq_chan_det
  import irq_trig_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  trig_mode_e mode_i,
  input  logic       lvl_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic prev_q, pend_q;
  logic rise, fall;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      unique case (mode_i)
        TRIG_HIGH: pend_q <= lvl_i;
        TRIG_LOW:  pend_q <= ~lvl_i;
        TRIG_RISE: pend_q <= (pend_q & ~clr_i) | rise;  // set beats clear
        TRIG_FALL: pend_q <= (pend_q & ~clr_i) | fall;
        default:   pend_q <= pend_q;
      endcase
    end
  end

  assign pend_o = pend_q;

  // R2
  high_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_HIGH) |=> (pend_q == $past(lvl_i)));

  // R3
  low_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LOW) |=> (pend_q != $past(lvl_i)));

  // R4
  edge_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == TRIG_RISE || mode_i == TRIG_FALL) && pend_q && !clr_i) |=> pend_q);

  // R9
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_RISE && lvl_i && !prev_q) |=> pend_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 15,
  parameter int OUT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     pend_i,
  output logic [OUT_W-1:0] top_o
);
  always_comb begin
    top_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) top_o = OUT_W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect
  import irq_trig_pkg::*;
#(
  parameter int NUM_CH  = 15,
  parameter int HI_BASE = 8,
  parameter int REG_W   = 16,
  localparam int ID_W   = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] irq_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [ID_W-1:0]   top_ch_o
);
  logic [NUM_CH-1:0] lvl;

  irq_sync #(.W(NUM_CH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (lvl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int  CH     = g + 1;
    localparam bit  IN_HI  = (CH >= HI_BASE);
    localparam int  K      = IN_HI ? CH - HI_BASE : CH - 1;
    localparam logic SEL   = IN_HI ? 1'b0 : 1'b1;

    trig_mode_e mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mode_q <= TRIG_HIGH;
      else if (cfg_we_i && cfg_sel_i == SEL)  mode_q <= trig_mode_e'(cfg_wdata_i[2*K +: 2]);
    end

    irq_chan_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_q),
      .lvl_i  (lvl[g]),
      .clr_i  (clr_i[g]),
      .pend_o (pend_o[g])
    );

    // R7
    mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_sel_i == SEL) |=> (mode_q == trig_mode_e'($past(cfg_wdata_i[2*K +: 2]))));
  end

  irq_prio_enc #(.N(NUM_CH), .OUT_W(ID_W)) u_enc (
    .pend_i (pend_o),
    .top_o  (top_ch_o)
  );

  // R8
  none_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o == '0) == (top_ch_o == '0)));

  // R8
  top_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_ch_o != '0) |-> (pend_o[top_ch_o - 1'b1] && ((pend_o >> top_ch_o) == '0)));
endmodule

// File: tb/irq_trigger_detect_bench.sv
module irq_trigger_detect_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] irq_i = '0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [14:0] clr_i = '0;
  logic [14:0] pend_o;
  logic [3:0]  top_ch_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_trigger_detect u_irq_trigger_detect (
    .clk_i, .rst_ni, .irq_i, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .clr_i, .pend_o, .top_ch_o
  );

  // {irq, clr, exp_pend, exp_top}
  // ch1 high, ch2 low, ch3 rise, ch4 fall, ch8 rise, ch9 fall, others high
  localparam logic [48:0] VEC [8] = '{
    {15'h0000, 15'h0000, 15'h0002, 4'd2},   // R3 tied-low pending
    {15'h000F, 15'h0000, 15'h0005, 4'd3},   // R2 R4
    {15'h0000, 15'h0000, 15'h000E, 4'd4},   // R5 R4 R3
    {15'h0000, 15'h000E, 15'h0002, 4'd2},   // R6 level not cleared
    {15'h0180, 15'h0000, 15'h0082, 4'd8},   // R4 R7
    {15'h0000, 15'h0000, 15'h0182, 4'd9},   // R5 R8
    {15'h4002, 15'h0080, 15'h4100, 4'd15},  // R6 R8
    {15'h0000, 15'h0100, 15'h0002, 4'd2}    // R6
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; irq_i = '0; clr_i = '0; cfg_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    do_reset();
    @(negedge clk_i);
    chk("R1 pend", {1'b0, pend_o}, 16'h0000);
    chk("R1 top", {12'h0, top_ch_o}, 16'd0);

    // R1 default high level, R2 latency on ch5
    irq_i = 15'h0010;
    repeat (2) @(negedge clk_i);
    chk("R2 early", {1'b0, pend_o}, 16'h0000);
    @(negedge clk_i);
    chk("R1 R2 ch5", {1'b0, pend_o}, 16'h0010);
    chk("R8 ch5", {12'h0, top_ch_o}, 16'd5);

    // vector table
    do_reset();
    cfg_write(1'b1, 16'h00E4);
    cfg_write(1'b0, 16'h000E);
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      irq_i = VEC[i][48:34];
      clr_i = VEC[i][33:19];
      @(negedge clk_i);
      clr_i = '0;
      repeat (3) @(negedge clk_i);
      chk($sformatf("R2-8 vec%0d pend", i), {1'b0, pend_o}, {1'b0, VEC[i][18:4]});
      chk($sformatf("R8 vec%0d top", i), {12'h0, top_ch_o}, {12'h0, VEC[i][3:0]});
    end

    // R3 R7: low mode on tied-low ch15 then ch7
    do_reset();
    cfg_write(1'b0, 16'h4000);
    @(negedge clk_i);
    chk("R3 R7 ch15", {1'b0, pend_o}, 16'h4000);
    chk("R8 ch15", {12'h0, top_ch_o}, 16'd15);
    cfg_write(1'b1, 16'h1000);
    @(negedge clk_i);
    chk("R7 ch7", {1'b0, pend_o}, 16'h4040);
    chk("R8 ch15 over ch7", {12'h0, top_ch_o}, 16'd15);
    repeat (5) @(negedge clk_i);
    chk("R3 steady", {1'b0, pend_o}, 16'h4040);

    // R9 set beats clear, then R6 clear
    do_reset();
    cfg_write(1'b1, 16'h0020);
    irq_i = 15'h0004;
    repeat (2) @(negedge clk_i);
    clr_i = 15'h0004;
    @(negedge clk_i);
    clr_i = '0;
    chk("R9 set wins", {1'b0, pend_o}, 16'h0004);
    clr_i = 15'h0004;
    @(negedge clk_i);
    clr_i = '0;
    chk("R6 cleared", {1'b0, pend_o}, 16'h0000);
    chk("R8 none", {12'h0, top_ch_o}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule